// File: doc/BRIEF.md
# Fixed-Point Homogeneous Vertex Transformer

This block applies a 3x4 affine position matrix to three-component points kept in a memory of 32-bit words. Each point occupies three consecutive words, and the block writes each result back over the point it came from. The block has one multiplier and one adder per output row. All three rows see the same coordinate in the same cycle, so the three matrix columns are walked one after another while the input words stream in one per clock. A point takes eight cycles: three reads, two cycles to drain the arithmetic, and three write-backs.

Two modes are available. Point mode adds the translation column, as a homogeneous w of 1 would. Vector mode leaves the translation out, which suits surface normals. For every point, a plane selector forwards two of the three transformed coordinates as a projected pair with a one-cycle strobe, for use by a later screen-mapping stage. A run starts on a pulse and walks the points from address 0 upward. It ends with a one-cycle done pulse when the read counter reaches three times the requested count.

Top module: `vtx_xform`

## Requirements
- R1: After reset, busy, done, mem_rd, mem_we and pair_valid are all 0 until a run is started.
- R2: Each product is the full signed product of two 16.16 words shifted right arithmetically by 16 (rounding toward minus infinity), keeping the low 32 bits. Sums wrap modulo 2^32.
- R3: Matrix entries are loaded through mat_idx = row*4 + col, with row 0..2 and col 0..3, where col 3 is the translation. In point mode, output row r = m[r][0]*X + m[r][1]*Y + m[r][2]*Z + m[r][3].
- R4: In vector mode (vec_mode = 1 at start), the translation entry m[r][3] is not added.
- R5: Point k reads addresses 3k, 3k+1 and 3k+2 in consecutive cycles. The memory returns data one cycle after mem_rd. The rows 0, 1 and 2 are written to the same three addresses 5, 6 and 7 cycles after the X read. The next X read follows 8 cycles after the previous one. mem_rd and mem_we are never high together.
- R6: The plane code sampled at start selects the pair (pair_a, pair_b): 00 → (X', Y'), 10 → (X', Z'), 11 → (Y', Z'). Code 01 behaves like 00.
- R7: pair_valid is a one-cycle pulse for each point, in the same cycle as that point's X write-back.
- R8: busy is high from the cycle after the start pulse through the last write-back. done pulses for one cycle immediately after, with busy low. A start with count 0 pulses done in the cycle after the start and touches no memory.
- R9: While busy, start, count, vec_mode, plane and matrix writes are ignored. The running pass keeps its mode, plane, count and matrix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, taken when idle |
| vec_mode | input | 1 | 1: vector mode (no translation) |
| plane | input | 2 | Projected-pair selector |
| count | input | CW | Number of points to transform |
| mat_we | input | 1 | Matrix entry write strobe |
| mat_idx | input | 4 | Entry index row*4+col |
| mat_data | input | 32 | Entry value, signed 16.16 |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word address |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| mem_wdata | output | 32 | Write-back data |
| pair_valid | output | 1 | Projected pair strobe |
| pair_a | output | 32 | First projected coordinate |
| pair_b | output | 32 | Second projected coordinate |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The start pulse is sampled at an edge, and the X read of point k appears 8k cycles later. Its three write-backs and the pair strobe follow 5, 6 and 7 cycles after that X read, and done comes 8·count cycles after the first read. The bench sets the expected edge at the moment it drives start. On every falling edge it derives from the cycle count the point index and the phase within the point, and from these the expected strobe, address, data and pair. It compares them against the ports, so any result that is one cycle early or late is reported as a mismatch. Expected results come from a snapshot of the memory and a bench-side matrix copy, both taken when start is driven.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
  localparam int unsigned FX_W = 32;
  localparam int unsigned FX_F = 16;
  localparam int unsigned ROWS = 3;
  localparam int unsigned COLS = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_RY, ST_RZ, ST_MZ, ST_AZ, ST_WX, ST_WY, ST_WZ
  } vx_state_t;

  typedef enum logic [1:0] {ACC_HOLD, ACC_INIT, ACC_ADD} acc_op_t;

  // signed 16.16 product, floor-truncated, low word kept
  function automatic logic signed [FX_W-1:0] fx_mul(
    input logic signed [FX_W-1:0] a,
    input logic signed [FX_W-1:0] b);
    logic signed [2*FX_W-1:0] full;
    full = a * b;
    return full[FX_F+FX_W-1:FX_F];
  endfunction
endpackage

// File: rtl/vtx_lane.sv
module vtx_lane import vtx_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mul_en,
  input  logic [1:0]             col_sel,
  input  logic signed [FX_W-1:0] din,
  input  logic signed [FX_W-1:0] row_m [COLS],
  input  acc_op_t                acc_op,
  input  logic                   use_trans,
  output logic signed [FX_W-1:0] acc_q
);
  logic signed [FX_W-1:0] prod_q;
  logic signed [FX_W-1:0] coef;
  logic signed [FX_W-1:0] trans;

  assign coef  = row_m[col_sel];
  assign trans = use_trans ? row_m[COLS-1] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      if (mul_en) prod_q <= fx_mul(din, coef);
      case (acc_op)
        ACC_INIT: acc_q <= prod_q + trans;
        ACC_ADD:  acc_q <= acc_q + prod_q;
        default:  acc_q <= acc_q;
      endcase
    end
  end
endmodule

// File: rtl/vtx_plane.sv
module vtx_plane import vtx_pkg::*; (
  input  logic [1:0]      plane,
  input  logic [FX_W-1:0] cx,
  input  logic [FX_W-1:0] cy,
  input  logic [FX_W-1:0] cz,
  output logic [FX_W-1:0] pa,
  output logic [FX_W-1:0] pb
);
  always_comb begin
    case (plane)
      2'b10:   begin pa = cx; pb = cz; end
      2'b11:   begin pa = cy; pb = cz; end
      default: begin pa = cx; pb = cy; end
    endcase
  end
endmodule

// File: rtl/vtx_seq.sv
module vtx_seq import vtx_pkg::*; #(
  parameter int AW = 12,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mul_en,
  output logic [1:0]    col_sel,
  output acc_op_t       acc_op,
  output logic [1:0]    wsel,
  output logic          wb_first
);
  localparam int LW = CW + 2;

  vx_state_t     st_q;
  logic [LW-1:0] lim_q, rd_cnt_q, lim_d, cnt_ext;
  logic [AW-1:0] ptr_q;
  logic [1:0]    offs;
  logic          done_q, last_pt;

  assign cnt_ext = {2'b00, count};
  assign lim_d   = (cnt_ext << 1) + cnt_ext;
  assign last_pt = (rd_cnt_q == lim_q);
  assign accept  = start && (st_q == ST_IDLE);
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lim_q    <= '0;
      rd_cnt_q <= '0;
      ptr_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mem_rd) rd_cnt_q <= rd_cnt_q + 1'b1;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (count == '0) done_q <= 1'b1;
          else begin
            st_q     <= ST_RX;
            ptr_q    <= '0;
            rd_cnt_q <= '0;
            lim_q    <= lim_d;
          end
        end
        ST_RX: st_q <= ST_RY;
        ST_RY: st_q <= ST_RZ;
        ST_RZ: st_q <= ST_MZ;
        ST_MZ: st_q <= ST_AZ;
        ST_AZ: st_q <= ST_WX;
        ST_WX: st_q <= ST_WY;
        ST_WY: st_q <= ST_WZ;
        ST_WZ: if (last_pt) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + AW'(3);
          st_q  <= ST_RX;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd  = 1'b0;
    mem_we  = 1'b0;
    offs    = 2'd0;
    mul_en  = 1'b0;
    col_sel = 2'd0;
    acc_op  = ACC_HOLD;
    wsel    = 2'd0;
    case (st_q)
      ST_RX: begin mem_rd = 1'b1; offs = 2'd0; end
      ST_RY: begin mem_rd = 1'b1; offs = 2'd1; mul_en = 1'b1; col_sel = 2'd0; end
      ST_RZ: begin
        mem_rd = 1'b1; offs = 2'd2; mul_en = 1'b1; col_sel = 2'd1; acc_op = ACC_INIT;
      end
      ST_MZ: begin mul_en = 1'b1; col_sel = 2'd2; acc_op = ACC_ADD; end
      ST_AZ: acc_op = ACC_ADD;
      ST_WX: begin mem_we = 1'b1; offs = 2'd0; wsel = 2'd0; end
      ST_WY: begin mem_we = 1'b1; offs = 2'd1; wsel = 2'd1; end
      ST_WZ: begin mem_we = 1'b1; offs = 2'd2; wsel = 2'd2; end
      default: ;
    endcase
  end

  assign mem_addr = ptr_q + AW'(offs);
  assign wb_first = (st_q == ST_WX);
endmodule

// File: rtl/vtx_xform.sv
module vtx_xform import vtx_pkg::*; #(
  parameter int AW = 12,
  parameter int CW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            vec_mode,
  input  logic [1:0]      plane,
  input  logic [CW-1:0]   count,
  input  logic            mat_we,
  input  logic [3:0]      mat_idx,
  input  logic [FX_W-1:0] mat_data,
  output logic            mem_rd,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  input  logic [FX_W-1:0] mem_rdata,
  output logic [FX_W-1:0] mem_wdata,
  output logic            pair_valid,
  output logic [FX_W-1:0] pair_a,
  output logic [FX_W-1:0] pair_b,
  output logic            busy,
  output logic            done
);
  logic signed [FX_W-1:0] mat_q [ROWS][COLS];
  logic signed [FX_W-1:0] acc [ROWS];
  logic                   vec_q;
  logic [1:0]             plane_q;
  logic                   accept, mul_en, wb_first, mat_take;
  logic [1:0]             col_sel, wsel;
  acc_op_t                acc_op;

  assign mat_take = mat_we && !busy && (mat_idx[3:2] != 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= 1'b0;
      plane_q <= 2'b00;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mat_q[r][c] <= '0;
    end else begin
      if (accept) begin
        vec_q   <= vec_mode;
        plane_q <= plane;
      end
      if (mat_take) mat_q[mat_idx[3:2]][mat_idx[1:0]] <= mat_data;
    end
  end

  vtx_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .accept(accept), .busy(busy), .done(done),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mul_en(mul_en), .col_sel(col_sel), .acc_op(acc_op),
    .wsel(wsel), .wb_first(wb_first)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_lane
    vtx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .mul_en(mul_en), .col_sel(col_sel),
      .din(signed'(mem_rdata)), .row_m(mat_q[r]), .acc_op(acc_op),
      .use_trans(!vec_q), .acc_q(acc[r])
    );
  end

  assign mem_wdata  = acc[wsel];
  assign pair_valid = wb_first;

  vtx_plane u_plane (
    .plane(plane_q), .cx(acc[0]), .cy(acc[1]), .cz(acc[2]),
    .pa(pair_a), .pb(pair_b)
  );
endmodule

// File: rtl/vtx_xform_chk.sv
module vtx_xform_chk #(
  parameter int AW = 12,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          pair_valid
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_we)); // R5
  AST_WB_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> ($past(mem_rd, 5) && mem_addr == $past(mem_addr, 5))); // R5
  AST_PAIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pair_valid |=> !pair_valid); // R7
  AST_PAIR_ON_WB: assert property (@(posedge clk) disable iff (!rst_n) pair_valid |-> $rose(mem_we)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_START_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count != '0) |=> (busy && mem_rd && mem_addr == '0)); // R5
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |=> busy); // R9
endmodule

bind vtx_xform vtx_xform_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .count(count), .busy(busy),
  .done(done), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
  .pair_valid(pair_valid)
);

// File: tb/tb_vtx_xform.sv
`timescale 1ns/1ps
module tb_vtx_xform;
  localparam int AW = 12;
  localparam int CW = 10;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, vec_mode, mat_we, mem_rd, mem_we, pair_valid, busy, done;
  logic [1:0] plane;
  logic [CW-1:0] count;
  logic [3:0] mat_idx;
  logic [31:0] mat_data, mem_rdata, mem_wdata, pair_a, pair_b;
  logic [AW-1:0] mem_addr;

  vtx_xform #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_mode(vec_mode), .plane(plane),
    .count(count), .mat_we(mat_we), .mat_idx(mat_idx), .mat_data(mat_data),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .pair_valid(pair_valid), .pair_a(pair_a), .pair_b(pair_b),
    .busy(busy), .done(done)
  );

  logic [31:0] bmem [0:63];
  logic pl_we = 1'b0;
  logic [5:0] pl_addr = '0;
  logic [31:0] pl_data = '0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pl_we) bmem[pl_addr] <= pl_data;
    if (mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= bmem[mem_addr[5:0]];
  end

  // reference model state
  int bm [12];
  int res [4][3];
  int e = -1000, npts = 0, done_cyc = -1;
  logic [1:0] pl = 2'b00;
  bit started = 1'b0, tests_done = 1'b0;
  string tag_w = "R3";
  int total = 0, fails = 0;

  function automatic int fxm(int a, int b); // R2: floor of product >> 16
    longint p;
    p = longint'(a) * longint'(b);
    return int'(p >>> 16);
  endfunction

  function automatic int xf(int r, int x, int y, int z, bit v);
    return fxm(bm[4*r], x) + fxm(bm[4*r+1], y) + fxm(bm[4*r+2], z) + (v ? 0 : bm[4*r+3]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cyc=%0d got=%0h exp=%0h", req, what, cyc, got, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int rel, k, ph, ea, pa_e, pb_e;
      bit inrun, e_rd, e_we, e_pv, e_done;
      string rq;
      rel   = cyc - e;
      inrun = (rel >= 0) && (rel < 8*npts);
      k     = inrun ? rel / 8 : 0;
      ph    = inrun ? rel % 8 : 0;
      e_rd  = inrun && ph < 3;
      e_we  = inrun && ph >= 5;
      e_pv  = inrun && ph == 5;
      e_done = (cyc == done_cyc);
      ea    = 3*k + (ph < 3 ? ph : ph - 5);
      rq    = started ? "R8" : "R1";
      chk(busy == inrun, rq, "busy", busy, inrun);
      chk(done == e_done, rq, "done", done, e_done);
      chk(mem_rd == e_rd, started ? "R5" : "R1", "mem_rd", mem_rd, e_rd);
      chk(mem_we == e_we, started ? "R5" : "R1", "mem_we", mem_we, e_we);
      chk(pair_valid == e_pv, started ? "R7" : "R1", "pair_valid", pair_valid, e_pv);
      if (e_rd || e_we) chk(int'(mem_addr) == ea, "R5", "mem_addr", mem_addr, ea);
      if (e_we) chk(mem_wdata == res[k][ph-5], tag_w, "mem_wdata", mem_wdata, res[k][ph-5]);
      if (e_pv) begin
        case (pl)
          2'b10:   begin pa_e = res[k][0]; pb_e = res[k][2]; end
          2'b11:   begin pa_e = res[k][1]; pb_e = res[k][2]; end
          default: begin pa_e = res[k][0]; pb_e = res[k][1]; end
        endcase
        chk(pair_a == pa_e, "R6", "pair_a", pair_a, pa_e);
        chk(pair_b == pb_e, "R6", "pair_b", pair_b, pb_e);
      end
    end
    if (cyc > WD_LIMIT) chk(1'b0, "WD", "watchdog", cyc, WD_LIMIT);
    if (tests_done || cyc > WD_LIMIT) begin
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic preload(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    pl_we = 1'b1; pl_addr = a[5:0]; pl_data = d;
    @(posedge clk); #1;
    pl_we = 1'b0;
  endtask

  task automatic set_mat(input int idx, input logic [31:0] v);
    @(posedge clk); #1;
    mat_we = 1'b1; mat_idx = idx[3:0]; mat_data = v; bm[idx] = int'(v);
    @(posedge clk); #1;
    mat_we = 1'b0;
  endtask

  task automatic run(input int n, input bit v, input logic [1:0] p, input string t);
    @(posedge clk); #1;
    start = 1'b1; count = n[CW-1:0]; vec_mode = v; plane = p;
    for (int kk = 0; kk < 4; kk++)
      for (int r = 0; r < 3; r++)
        res[kk][r] = xf(r, int'(bmem[3*kk]), int'(bmem[3*kk+1]), int'(bmem[3*kk+2]), v);
    pl = p; npts = n; tag_w = t; started = 1'b1;
    e = cyc + 1;
    done_cyc = (n == 0) ? e : e + 8*n;
    @(posedge clk); #1;
    start = 1'b0; count = '0; vec_mode = 1'b0; plane = 2'b00;
  endtask

  task automatic wait_done();
    while (cyc < done_cyc + 2) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vec_mode = 1'b0; plane = 2'b00; count = '0;
    mat_we = 1'b0; mat_idx = '0; mat_data = '0;
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk); // R1 idle checks run meanwhile
    preload(0, 32'h0001_0000); preload(1, 32'h0002_0000); preload(2, 32'h0003_0000);
    preload(3, 32'hFFFE_8000); preload(4, 32'h0000_4000); preload(5, 32'hFFFE_0000);
    preload(6, 32'hFFFE_B334); preload(7, 32'h0001_2345); preload(8, 32'hFFFF_0001);
    preload(9, 32'h0064_C000); preload(10, 32'hFFF8_E000); preload(11, 32'h0000_0007);
    // matrix A: quarter turn about Z plus a shift (R3)
    set_mat(0, 32'h0); set_mat(1, 32'hFFFF_0000); set_mat(2, 32'h0); set_mat(3, 32'h0002_8000);
    set_mat(4, 32'h0001_0000); set_mat(5, 32'h0); set_mat(6, 32'h0); set_mat(7, 32'hFFFE_C000);
    set_mat(8, 32'h0); set_mat(9, 32'h0); set_mat(10, 32'h0001_0000); set_mat(11, 32'h0000_8000);
    run(2, 1'b0, 2'b00, "R3");
    wait_done();
    // vector mode, X/Z pair, with ignored stimulus mid-run (R4, R9)
    run(3, 1'b1, 2'b10, "R4/R9");
    repeat (6) @(posedge clk);
    #1;
    start = 1'b1; count = 10'd1; vec_mode = 1'b0; plane = 2'b11;
    mat_we = 1'b1; mat_idx = 4'd0; mat_data = 32'h7FFF_0000;
    @(posedge clk); #1;
    start = 1'b0; count = '0; vec_mode = 1'b0; plane = 2'b00; mat_we = 1'b0;
    wait_done();
    // matrix B: fractional and negative entries, floor truncation (R2)
    set_mat(0, 32'h0000_8000); set_mat(1, 32'hFFFF_4000); set_mat(2, 32'h0000_3333); set_mat(3, 32'h0001_0000);
    set_mat(4, 32'hFFFF_CCCD); set_mat(5, 32'h0000_8000); set_mat(6, 32'hFFFF_8000); set_mat(7, 32'hFFFF_0000);
    set_mat(8, 32'h0000_0001); set_mat(9, 32'hFFFF_FFFF); set_mat(10, 32'h0000_B505); set_mat(11, 32'h0000_4000);
    run(4, 1'b0, 2'b11, "R2/R3");
    wait_done();
    run(2, 1'b0, 2'b01, "R6");
    wait_done();
    run(0, 1'b0, 2'b00, "R8");
    wait_done();
    repeat (3) @(posedge clk);
    tests_done = 1'b1;
  end
endmodule